// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and brings the memory from power-up to a state where normal traffic may start. After reset it holds the clock enable low and keeps the chip deselected for a programmable settling period. It then raises the clock enable with a no-operation cycle and issues a fixed series of commands on the command/address bus. Between commands it inserts idle cycles sized by parameters for mode-register load time, precharge time and refresh cycle time.

The series is: precharge all banks, load the extended mode register with the DLL enabled, load the base mode register with the DLL-reset bit set, precharge all banks again, two auto refreshes, and a last base mode register load with the DLL-reset bit clear. The mode-register fields (burst length code, burst type, CAS latency code) and the extended-register word are parameters. Two flags come out. `init_done` rises once the last mode load has settled. `read_ok` rises once the DLL lock period, counted from the DLL-reset load, has run out. A user must hold back reads until `read_ok` and all other traffic until `init_done`.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is active, and for at least PWRUP_CYC and at most PWRUP_CYC+4 cycles after reset release, `cke` is 0, `cs_n` is 1, and `init_done` and `read_ok` are 0.
- R2: The first cycle with `cke` high carries NOP ({cs_n,ras_n,cas_n,we_n}=0111). `cke` then stays high until the next reset.
- R3: After the CKE-raise cycle, the non-NOP commands are issued in this order and no others follow: PRE, LMR(ext), LMR(base, DLL reset), PRE, REF, REF, LMR(base).
- R4: Precharge-all is encoded 0010 on {cs_n,ras_n,cas_n,we_n} with addr[10]=1. The first precharge comes exactly one cycle after the CKE-raise cycle.
- R5: LMR is encoded 0000. The extended load has ba=01 and addr=EXT_MODE with addr[0] forced to 0 (DLL enabled).
- R6: The DLL-reset load has ba=00 and addr = {addr[12:9]=0, addr[8]=1, addr[7]=0, addr[6:4]=CL_CODE, addr[3]=BURST_TYPE, addr[2:0]=BL_CODE}.
- R7: The final load has ba=00 and the same word as R6 with addr[8]=0, so addr[12:7] are all zero.
- R8: Auto refresh is encoded 0001.
- R9: A command is followed by the next one exactly T_RP cycles after a precharge, T_MRD cycles after an LMR, and T_RFC cycles after a refresh. Only NOPs appear in between.
- R10: `init_done` rises exactly T_MRD cycles after the final LMR. It stays high, and only NOPs follow.
- R11: `read_ok` rises exactly DLL_LOCK_CYC cycles after the DLL-reset LMR, whatever the timing of `init_done`. The two may rise in the same cycle. `read_ok` stays high.
- R12: Asserting `rst_n` at any point drops `cke`, deselects the bus, clears both flags at once, and a later release restarts the whole series from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank / register select |
| addr | output | ADDR_W | Address / opcode |
| init_done | output | 1 | Initialization complete |
| read_ok | output | 1 | DLL lock period over, reads allowed |

## Verification
The two functions that can land in the same cycle are the completion flag and the read-lockout expiry. They run from separate timers started at different commands. A second instance is built with DLL_LOCK_CYC set equal to the sum of the delays from the DLL-reset load to completion. The bench records the rise cycle of each flag on that instance and requires them to be identical, while the first instance keeps the lockout longer so that the two rise apart. Resets fired mid-series, after the lock timer has already started, show that neither flag leaks through a restart.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } ddr_cmd_e;

  typedef enum logic [3:0] {
    ST_POWER,
    ST_WAKE,
    ST_PRE_A,
    ST_EXT_LD,
    ST_DLL_RST,
    ST_PRE_B,
    ST_REF_A,
    ST_REF_B,
    ST_MODE_LD,
    ST_GAP,
    ST_READY
  } init_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_delay.sv
module ddr_init_delay #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= CNT_W'(RST_VAL);
    else
      cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero); // R9

endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
  parameter int unsigned LOCK_CYC = 200,
  localparam int unsigned LW      = $clog2(LOCK_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic read_ok
);

  logic [LW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          ok_q, ok_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    ok_d  = ok_q;
    if (start) begin
      cnt_d = LW'(LOCK_CYC - 1);
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        ok_d  = 1'b1;
        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      ok_q  <= ok_d;
    end
  end

  assign read_ok = ok_q;

  AST_READ_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |=> read_ok); // R11
  AST_READ_OK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_ok) |-> $past(run_q)); // R11

endmodule

// File: rtl/ddr_init_cmdreg.sv
module ddr_init_cmdreg
  import ddr_init_pkg::*;
#(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_d,
  input  ddr_cmd_e          cmd_d,
  input  logic [BA_W-1:0]   ba_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              done_d,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  logic              cke_q;
  ddr_cmd_e          cmd_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b0;
      cmd_q  <= CMD_DESEL;
      ba_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cke_q  <= cke_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign cke  = cke_q;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba   = ba_q;
  assign addr = addr_q;
  assign done = done_q;

  AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cke_q |=> cke_q); // R2
  AST_DESEL_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |-> (cmd_q == CMD_DESEL)); // R1
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cmd_q == CMD_NOP) && cke_q); // R10

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned BA_W         = 2,
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned PWRUP_CYC    = 20000,
  parameter int unsigned T_MRD        = 2,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_RFC        = 8,
  parameter int unsigned DLL_LOCK_CYC = 200,
  parameter logic [2:0]  BL_CODE      = 3'b010,
  parameter logic        BURST_TYPE   = 1'b0,
  parameter logic [2:0]  CL_CODE      = 3'b010,
  parameter logic [ADDR_W-1:0] EXT_MODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              read_ok
);

  localparam int unsigned MAX_T = max2(max2(PWRUP_CYC, T_MRD), max2(T_RP, T_RFC));
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 2);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 2);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // mode words
  logic [ADDR_W-1:0] base_word, ext_word;
  always_comb begin
    base_word      = '0;
    base_word[2:0] = BL_CODE;
    base_word[3]   = BURST_TYPE;
    base_word[6:4] = CL_CODE;
    ext_word       = EXT_MODE;
    ext_word[0]    = 1'b0;      // DLL enable
  end

  init_state_e       state_q, state_d, ret_q, ret_d;
  logic              ld;
  logic [CNT_W-1:0]  ld_val;
  logic              gap_zero;
  logic              cke_d;
  ddr_cmd_e          cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic              lock_start;

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    ld      = 1'b0;
    ld_val  = '0;
    cke_d   = 1'b1;
    cmd_d   = CMD_NOP;
    ba_d    = '0;
    addr_d  = '0;
    unique case (state_q)
      ST_POWER: begin
        cke_d = 1'b0;
        cmd_d = CMD_DESEL;
        if (gap_zero) state_d = ST_WAKE;
      end
      ST_WAKE: state_d = ST_PRE_A;
      ST_PRE_A: begin
        cmd_d = CMD_PRE; addr_d[10] = 1'b1;
        ld = 1'b1; ld_val = LD_RP; ret_d = ST_EXT_LD; state_d = ST_GAP;
      end
      ST_EXT_LD: begin
        cmd_d = CMD_LMR; ba_d = BA_W'(1); addr_d = ext_word;
        ld = 1'b1; ld_val = LD_MRD; ret_d = ST_DLL_RST; state_d = ST_GAP;
      end
      ST_DLL_RST: begin
        cmd_d = CMD_LMR; addr_d = base_word; addr_d[8] = 1'b1;
        ld = 1'b1; ld_val = LD_MRD; ret_d = ST_PRE_B; state_d = ST_GAP;
      end
      ST_PRE_B: begin
        cmd_d = CMD_PRE; addr_d[10] = 1'b1;
        ld = 1'b1; ld_val = LD_RP; ret_d = ST_REF_A; state_d = ST_GAP;
      end
      ST_REF_A: begin
        cmd_d = CMD_REF;
        ld = 1'b1; ld_val = LD_RFC; ret_d = ST_REF_B; state_d = ST_GAP;
      end
      ST_REF_B: begin
        cmd_d = CMD_REF;
        ld = 1'b1; ld_val = LD_RFC; ret_d = ST_MODE_LD; state_d = ST_GAP;
      end
      ST_MODE_LD: begin
        cmd_d = CMD_LMR; addr_d = base_word;
        ld = 1'b1; ld_val = LD_MRD; ret_d = ST_READY; state_d = ST_GAP;
      end
      ST_GAP:   if (gap_zero) state_d = ret_q;
      ST_READY: ;
      default:  state_d = ST_POWER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_POWER;
      ret_q   <= ST_POWER;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
    end
  end

  assign lock_start = (state_q == ST_DLL_RST);

  ddr_init_delay #(.CNT_W(CNT_W), .RST_VAL(PWRUP_CYC - 1)) u_delay (
    .clk(clk), .rst_n(rst_int_n), .load(ld), .load_val(ld_val), .zero(gap_zero)
  );

  ddr_init_lock #(.LOCK_CYC(DLL_LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_int_n), .start(lock_start), .read_ok(read_ok)
  );

  ddr_init_cmdreg #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_int_n),
    .cke_d(cke_d), .cmd_d(cmd_d), .ba_d(ba_d), .addr_d(addr_d),
    .done_d(state_q == ST_READY),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .done(init_done)
  );

  AST_GAP_RETURNS_TO_CMD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_GAP && gap_zero) |=> (state_q != ST_GAP)); // R9
  AST_LOCK_STARTS_ONCE: assert property (@(posedge clk) disable iff (!rst_int_n)
    lock_start |=> !lock_start); // R11

endmodule

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;

  localparam int P    = 40;
  localparam int MRD  = 2;
  localparam int RP   = 3;
  localparam int RFC  = 8;
  localparam int LK0  = 30;
  localparam int LK1  = MRD + RP + RFC + RFC + MRD;  // coincides with done

  localparam logic [3:0] E_LMR = 4'b0000, E_REF = 4'b0001,
                         E_PRE = 4'b0010, E_NOP = 4'b0111;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;

  logic cke0, cs0, ras0, cas0, we0, done0, rok0;
  logic [1:0] ba0;
  logic [12:0] ad0;
  logic cke1, cs1, ras1, cas1, we1, done1, rok1;
  logic [1:0] ba1;
  logic [12:0] ad1;

  ddr_init_seq #(.PWRUP_CYC(P), .T_MRD(MRD), .T_RP(RP), .T_RFC(RFC),
    .DLL_LOCK_CYC(LK0), .BL_CODE(3'b010), .BURST_TYPE(1'b0),
    .CL_CODE(3'b010), .EXT_MODE(13'h0001)) u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke0), .cs_n(cs0), .ras_n(ras0),
    .cas_n(cas0), .we_n(we0), .ba(ba0), .addr(ad0),
    .init_done(done0), .read_ok(rok0));

  ddr_init_seq #(.PWRUP_CYC(P), .T_MRD(MRD), .T_RP(RP), .T_RFC(RFC),
    .DLL_LOCK_CYC(LK1), .BL_CODE(3'b011), .BURST_TYPE(1'b1),
    .CL_CODE(3'b110), .EXT_MODE(13'h0003)) u1 (
    .clk(clk), .rst_n(rst_n), .cke(cke1), .cs_n(cs1), .ras_n(ras1),
    .cas_n(cas1), .we_n(we1), .ba(ba1), .addr(ad1),
    .init_done(done1), .read_ok(rok1));

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] addr;
    bit          chk_ba_addr;
    int          gap;
    int          kind;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int nchk = 0, nfail = 0;

  task automatic chk(bit ok, string req, longint act, longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [12:0] mode_word(logic [2:0] bl, logic bt,
                                            logic [2:0] cl, logic dll_rst);
    return {4'b0000, dll_rst, 1'b0, cl, bt, bl};
  endfunction

  task automatic push(logic [3:0] c, logic [1:0] b, logic [12:0] a,
                      bit cba, int g, int k, string t);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.chk_ba_addr = cba;
    e.gap = g; e.kind = k; e.tag = t;
    exp_q.push_back(e);
  endtask

  // driver: expected command stream for u0
  task automatic push_seq();
    push(E_PRE, 2'b00, 13'h0400, 1'b0, 1,   0, "R3 R4");
    push(E_LMR, 2'b01, 13'h0000, 1'b1, RP,  1, "R3 R5");
    push(E_LMR, 2'b00, mode_word(3'b010, 1'b0, 3'b010, 1'b1), 1'b1, MRD, 2, "R3 R6");
    push(E_PRE, 2'b00, 13'h0400, 1'b0, MRD, 3, "R3 R4");
    push(E_REF, 2'b00, 13'h0000, 1'b0, RP,  4, "R3 R8");
    push(E_REF, 2'b00, 13'h0000, 1'b0, RFC, 5, "R3 R8");
    push(E_LMR, 2'b00, mode_word(3'b010, 1'b0, 3'b010, 1'b0), 1'b1, RFC, 6, "R3 R7");
  endtask

  // monitor / scoreboard
  int  cyc = 0;
  int  low_cnt, last_cyc, dll_cyc, mrs_cyc;
  bit  cke_seen, done_seen, rok_seen;
  int  u1_done_cyc, u1_rok_cyc;
  logic [12:0] u1_ext, u1_final;
  logic [3:0] c0;

  always @(negedge clk) begin
    cyc++;
    c0 = {cs0, ras0, cas0, we0};
    if (!rst_n) begin
      low_cnt = 0; last_cyc = 0; dll_cyc = 0; mrs_cyc = 0;
      cke_seen = 0; done_seen = 0; rok_seen = 0;
      u1_done_cyc = -1; u1_rok_cyc = -2; u1_ext = '1; u1_final = '1;
    end else begin
      if (!cke0) begin
        if (cke_seen) chk(1'b0, "R2 cke dropped", cke0, 1);
        low_cnt++;
        if (!cs0 || done0 || rok0)
          chk(1'b0, "R1 bus/flags during power wait", {cs0, done0, rok0}, 3'b100);
      end else if (!cke_seen) begin
        cke_seen = 1;
        chk(low_cnt >= P && low_cnt <= P + 4, "R1 power wait length", low_cnt, P);
        chk(c0 == E_NOP, "R2 NOP with CKE raise", c0, E_NOP);
        last_cyc = cyc;
      end else if (c0 != E_NOP) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected command", c0, E_NOP);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(c0 == e.cmd, e.tag, c0, e.cmd);
          chk(cyc - last_cyc == e.gap, "R9 spacing", cyc - last_cyc, e.gap);
          if (e.cmd == E_PRE) chk(ad0[10], "R4 A10", ad0[10], 1);
          if (e.chk_ba_addr) begin
            chk(ba0 == e.ba, e.tag, ba0, e.ba);
            chk(ad0 == e.addr, e.tag, ad0, e.addr);
          end
          if (e.kind == 2) dll_cyc = cyc;
          if (e.kind == 6) mrs_cyc = cyc;
          last_cyc = cyc;
        end
      end
      if (done0 && !done_seen) begin
        done_seen = 1;
        chk(mrs_cyc != 0 && cyc - mrs_cyc == MRD, "R10 done timing", cyc - mrs_cyc, MRD);
      end
      if (rok0 && !rok_seen) begin
        rok_seen = 1;
        chk(dll_cyc != 0 && cyc - dll_cyc == LK0, "R11 read_ok timing", cyc - dll_cyc, LK0);
      end
      // u1 observations
      if ({cs1, ras1, cas1, we1} == E_LMR) begin
        if (ba1 == 2'b01) u1_ext = ad1; else u1_final = ad1;
      end
      if (done1 && u1_done_cyc < 0) u1_done_cyc = cyc;
      if (rok1 && u1_rok_cyc < 0) u1_rok_cyc = cyc;
    end
  end

  task automatic wait_ready();
    while (!(done0 && rok0 && done1 && rok1)) @(negedge clk);
  endtask

  task automatic check_reset_state(string tag);
    chk(cke0 == 0 && cs0 == 1, tag, {cke0, cs0}, 2'b01);
    chk(done0 == 0 && rok0 == 0, tag, {done0, rok0}, 0);
    chk(cke1 == 0 && done1 == 0 && rok1 == 0, tag, {cke1, done1, rok1}, 0);
  endtask

  bit finished = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("R1 reset state");
    rst_n = 1'b1;
    push_seq();
    wait_ready();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all commands seen", exp_q.size(), 0);
    chk(cke0 && done0 && rok0, "R10 R11 flags hold", {cke0, done0, rok0}, 3'b111);
    chk(u1_done_cyc == u1_rok_cyc, "R11 coincident rise", u1_rok_cyc, u1_done_cyc);
    chk(u1_ext == 13'h0002, "R5 ext word A0 forced low", u1_ext, 13'h0002);
    chk(u1_final == mode_word(3'b011, 1'b1, 3'b110, 1'b0), "R7 u1 final word",
        u1_final, mode_word(3'b011, 1'b1, 3'b110, 1'b0));

    // reset after completion
    rst_n = 1'b0;
    exp_q.delete();
    #1;
    check_reset_state("R12 reset after ready");
    @(negedge clk);
    rst_n = 1'b1;
    push_seq();
    while (exp_q.size() > 4) @(negedge clk);
    repeat (2) @(negedge clk);
    // reset mid-series, lock timer already running
    rst_n = 1'b0;
    exp_q.delete();
    #1;
    check_reset_state("R12 reset mid-series");
    repeat (LK0 + 5) @(negedge clk);
    check_reset_state("R12 flags stay low in reset");
    rst_n = 1'b1;
    push_seq();
    wait_ready();
    repeat (15) @(negedge clk);
    chk(exp_q.size() == 0, "R12 full restart", exp_q.size(), 0);
    chk(u1_done_cyc == u1_rok_cyc, "R11 coincident after restart", u1_rok_cyc, u1_done_cyc);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule